// File: doc/BRIEF.md
# Receive Packet Buffer with Head Status

This block sits between a receive MAC and the host side of a network controller. The receive side pushes bytes one per beat, marking the first and last byte of each packet and giving a 4-bit completion code with the last byte. The block keeps the bytes in a circular byte store and one descriptor per finished packet in a small descriptor queue. The host sees a 16-bit status word for the packet at the head of the buffer. It reads that packet as 16-bit words and drops it with a discard command once it is done.

Two separate capacity limits apply. One is the number of finished packets the descriptor queue can hold; the other is the byte store. Each limit has its own level flag with its own drop behaviour. Reading past the end of the head packet is a host error. It raises a sticky underrun flag, which also drives the adapter-failure output, until a receive reset. Two one-cycle event pulses mark a finished packet and an early-threshold crossing.

Top module: `rx_pkt_buffer`

## Requirements
- R1: After `rst_n` is released, `headStatus` is 16'h8000, `rdData` is 0 and every flag and pulse output is low.
- R2: While at least one finished packet is held, `headStatus` is {1'b0, class, unread}. Here `unread` (bits 10..0) is the number of bytes of the head packet not yet read, and `class` (bits 14..11) is the completion code of that packet. The codes kept are 4'b1000 overrun, 4'b1001 oversize, 4'b1011 runt, 4'b1100 alignment, 4'b1101 CRC and 4'b0010 dribble; any other code is shown as 4'b0000.
- R3: While no finished packet is held, `headStatus` has bit 15 set and bits 14..11 zero. Bits 10..0 give the number of bytes stored so far for the packet being received, or 0 when none is in progress.
- R4: `rdData` shows the next two unread bytes of the head packet, the earlier byte in bits 7..0. When one byte is left, bits 15..8 are zero; with no finished packet or no unread byte, `rdData` is 0. A `rdReq` consumes two bytes, or one byte when only one is left.
- R5: `discardReq` removes the head packet together with its unread bytes, and the next cycle shows the next packet's status. When both are high in the same cycle, `discardReq` wins and `rdReq` is ignored. A discard with no finished packet has no effect.
- R6: `statusOverrun` is high while PKT_SLOTS (default 8) finished packets are held. A start beat arriving then is refused, and the whole packet is dropped. The flag drops as soon as a packet is discarded.
- R7: `rxOverrun` is high while the byte store holds DATA_DEPTH bytes. Bytes of a packet arriving then are dropped, and that packet is finished with code 4'b1000 and the count of bytes actually stored. The flag drops once bytes have been read out.
- R8: A `rdReq` (without `discardReq`) when no finished packet is held, or when the head packet has no unread byte, consumes nothing. It sets `rxUnderrun` and `adapterFail`, which stay high until `rxReset` or `rst_n`.
- R9: `rxReset` empties the buffer, abandons a packet in progress and clears all flags in the next cycle.
- R10: `receiving` is high from the cycle after an accepted first byte until the cycle after the last byte; a one-byte packet never raises it.
- R11: `rxComplete` is high for one cycle, the cycle after a packet's last byte is accepted, which is also the first cycle its descriptor is visible.
- R12: `rxEarly` is high for one cycle after a stored byte brings the count of the packet in progress equal to a nonzero `earlyThresh`.
- R13: Bytes that arrive outside a packet (no accepted start beat) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxReset | input | 1 | Synchronous receive reset |
| wrValid | input | 1 | A receive byte is present this cycle |
| wrStart | input | 1 | This byte is the first of a packet |
| wrEnd | input | 1 | This byte is the last of a packet |
| wrErrCode | input | 4 | Completion code, taken with the last byte |
| wrByte | input | 8 | Receive byte |
| earlyThresh | input | 11 | Byte count that fires the early event; 0 disables it |
| rdReq | input | 1 | Host consumes the word on rdData |
| discardReq | input | 1 | Host drops the head packet |
| rdData | output | 16 | Next unread word of the head packet |
| headStatus | output | 16 | Status word of the head packet |
| receiving | output | 1 | A packet is being stored |
| rxOverrun | output | 1 | Byte store is full |
| statusOverrun | output | 1 | Descriptor queue is full |
| rxUnderrun | output | 1 | Sticky read-past-end flag |
| adapterFail | output | 1 | Adapter failure indication |
| rxComplete | output | 1 | Packet finished pulse |
| rxEarly | output | 1 | Early threshold pulse |

## Verification
Directed packets try each completion code, including an unknown one, against the status class field. Odd and even lengths tell the two-byte and one-byte read steps apart. Single-byte packets fill the descriptor queue, and one long packet fills the byte store, so the two overrun paths show their different drop rules. Seeded random traffic then mixes starts, ends, reads, discards and receive resets in overlapping cycles. This is where same-cycle read-and-discard priority and simultaneous fill and drain are separated from the simpler sequential cases.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  localparam int LEN_W  = 11;
  localparam int CODE_W = 4;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  localparam logic [CODE_W-1:0] CODE_OVERRUN  = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_OVERSIZE = 4'b1001;
  localparam logic [CODE_W-1:0] CODE_RUNT     = 4'b1011;
  localparam logic [CODE_W-1:0] CODE_ALIGN    = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_CRC      = 4'b1101;
  localparam logic [CODE_W-1:0] CODE_DRIBBLE  = 4'b0010;

  // one finished packet
  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;
  } pkt_desc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             flush;
    logic             byteWr;
    logic             descPush;
    logic             descPop;
    logic [LEN_W-1:0] advance;
    pkt_desc_t        desc;
  } buf_strobe_t;

  function automatic logic [CODE_W-1:0] normCode(input logic [CODE_W-1:0] c);
    case (c)
      CODE_OVERRUN, CODE_OVERSIZE, CODE_RUNT,
      CODE_ALIGN, CODE_CRC, CODE_DRIBBLE: normCode = c;
      default:                            normCode = '0;
    endcase
  endfunction

endpackage

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int DATA_DEPTH = 2048,
  parameter int PKT_SLOTS  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  buf_strobe_t                    stb,
  input  logic [7:0]                     wrByte,
  output logic [$clog2(DATA_DEPTH):0]    bytesUsed,
  output logic [$clog2(PKT_SLOTS):0]     descCount,
  output pkt_desc_t                      headDesc,
  output logic [7:0]                     rdLo,
  output logic [7:0]                     rdHi
);

  localparam int PTR_W      = $clog2(DATA_DEPTH);
  localparam int USED_W     = PTR_W + 1;
  localparam int SLOT_W     = $clog2(PKT_SLOTS);
  localparam int SLOT_CNT_W = SLOT_W + 1;

  logic [7:0]       dataMem [DATA_DEPTH];
  pkt_desc_t        descMem [PKT_SLOTS];
  logic [PTR_W-1:0] wrPtr, rdPtr, rdPtrNext;
  logic [SLOT_W-1:0] descHead, descTail;

  assign rdPtrNext = rdPtr + PTR_W'(1);
  assign rdLo      = dataMem[rdPtr];
  assign rdHi      = dataMem[rdPtrNext];
  assign headDesc  = descMem[descHead];

  // storage arrays carry no reset; pointers decide what is valid
  always_ff @(posedge clk) begin
    if (stb.byteWr && !stb.flush) dataMem[wrPtr] <= wrByte;
    if (stb.descPush && !stb.flush) descMem[descTail] <= stb.desc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      bytesUsed <= '0;
      descHead  <= '0;
      descTail  <= '0;
      descCount <= '0;
    end else if (stb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      bytesUsed <= '0;
      descHead  <= '0;
      descTail  <= '0;
      descCount <= '0;
    end else begin
      if (stb.byteWr) wrPtr <= wrPtr + PTR_W'(1);
      rdPtr     <= rdPtr + PTR_W'(stb.advance);
      bytesUsed <= bytesUsed + USED_W'(stb.byteWr) - USED_W'(stb.advance);
      if (stb.descPush) descTail <= descTail + SLOT_W'(1);
      if (stb.descPop)  descHead <= descHead + SLOT_W'(1);
      descCount <= descCount + SLOT_CNT_W'(stb.descPush) - SLOT_CNT_W'(stb.descPop);
    end
  end

endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int DATA_DEPTH = 2048,
  parameter int PKT_SLOTS  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rxReset,
  input  logic                        wrValid,
  input  logic                        wrStart,
  input  logic                        wrEnd,
  input  logic [CODE_W-1:0]           wrErrCode,
  input  logic [LEN_W-1:0]            earlyThresh,
  input  logic                        rdReq,
  input  logic                        discardReq,
  input  logic [$clog2(DATA_DEPTH):0] bytesUsed,
  input  logic [$clog2(PKT_SLOTS):0]  descCount,
  input  pkt_desc_t                   headDesc,
  output buf_strobe_t                 stb,
  output logic [15:0]                 headStatus,
  output logic                        wordValid,
  output logic                        wordHasHi,
  output logic                        receiving,
  output logic                        rxOverrun,
  output logic                        statusOverrun,
  output logic                        rxUnderrun,
  output logic                        rxComplete,
  output logic                        rxEarly
);

  localparam int USED_W     = $clog2(DATA_DEPTH) + 1;
  localparam int SLOT_CNT_W = $clog2(PKT_SLOTS) + 1;

  logic             inPkt, pktOvr;
  logic [LEN_W-1:0] curCount, headUsed;

  logic             haveDesc, storeFull, slotsFull;
  logic             startOk, active, takeByte, hitFull, baseOvr;
  logic [LEN_W-1:0] baseCount, newCount, headRem, readStep;
  logic             doDiscard, doRead, badRead, hostBusy;

  always_comb begin
    haveDesc  = descCount != '0;
    storeFull = bytesUsed == USED_W'(DATA_DEPTH);
    slotsFull = descCount == SLOT_CNT_W'(PKT_SLOTS);
    headRem   = headDesc.len - headUsed;

    // receive side
    startOk   = wrValid && wrStart && !inPkt && !slotsFull;
    active    = wrValid && (inPkt || startOk);
    baseCount = startOk ? '0 : curCount;
    baseOvr   = startOk ? 1'b0 : pktOvr;
    takeByte  = active && !storeFull && (baseCount != LEN_MAX);
    hitFull   = active && storeFull;
    newCount  = baseCount + LEN_W'(takeByte);

    // host side; discard wins over read
    hostBusy  = haveDesc && (headRem != '0);
    doDiscard = discardReq && haveDesc;
    doRead    = rdReq && !discardReq && hostBusy;
    badRead   = rdReq && !discardReq && !hostBusy;
    readStep  = (headRem >= LEN_W'(2)) ? LEN_W'(2) : LEN_W'(1);

    stb.flush     = rxReset;
    stb.byteWr    = takeByte;
    stb.descPush  = active && wrEnd;
    stb.descPop   = doDiscard;
    stb.advance   = doDiscard ? headRem : (doRead ? readStep : '0);
    stb.desc.len  = newCount;
    stb.desc.code = (baseOvr || hitFull) ? CODE_OVERRUN : wrErrCode;

    if (haveDesc)
      headStatus = {1'b0, normCode(headDesc.code), headRem};
    else
      headStatus = {1'b1, 4'b0000, (inPkt ? curCount : LEN_W'(0))};

    wordValid     = hostBusy;
    wordHasHi     = headRem >= LEN_W'(2);
    receiving     = inPkt;
    rxOverrun     = storeFull;
    statusOverrun = slotsFull;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inPkt      <= 1'b0;
      pktOvr     <= 1'b0;
      curCount   <= '0;
      headUsed   <= '0;
      rxUnderrun <= 1'b0;
      rxComplete <= 1'b0;
      rxEarly    <= 1'b0;
    end else if (rxReset) begin
      inPkt      <= 1'b0;
      pktOvr     <= 1'b0;
      curCount   <= '0;
      headUsed   <= '0;
      rxUnderrun <= 1'b0;
      rxComplete <= 1'b0;
      rxEarly    <= 1'b0;
    end else begin
      if (active) begin
        inPkt    <= !wrEnd;
        curCount <= newCount;
        pktOvr   <= baseOvr || hitFull;
      end
      if (doDiscard)   headUsed <= '0;
      else if (doRead) headUsed <= headUsed + readStep;
      if (badRead) rxUnderrun <= 1'b1;
      rxComplete <= active && wrEnd;
      rxEarly    <= takeByte && (earlyThresh != '0) && (newCount == earlyThresh);
    end
  end

endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
  import rxbuf_pkg::*;
#(
  parameter int DATA_DEPTH = 2048,
  parameter int PKT_SLOTS  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxReset,
  input  logic        wrValid,
  input  logic        wrStart,
  input  logic        wrEnd,
  input  logic [3:0]  wrErrCode,
  input  logic [7:0]  wrByte,
  input  logic [10:0] earlyThresh,
  input  logic        rdReq,
  input  logic        discardReq,
  output logic [15:0] rdData,
  output logic [15:0] headStatus,
  output logic        receiving,
  output logic        rxOverrun,
  output logic        statusOverrun,
  output logic        rxUnderrun,
  output logic        adapterFail,
  output logic        rxComplete,
  output logic        rxEarly
);

  buf_strobe_t                 stb;
  logic [$clog2(DATA_DEPTH):0] bytesUsed;
  logic [$clog2(PKT_SLOTS):0]  descCount;
  pkt_desc_t                   headDesc;
  logic [7:0]                  rdLo, rdHi;
  logic                        wordValid, wordHasHi;

  rxbuf_ctrl #(.DATA_DEPTH(DATA_DEPTH), .PKT_SLOTS(PKT_SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxReset(rxReset),
    .wrValid(wrValid), .wrStart(wrStart), .wrEnd(wrEnd), .wrErrCode(wrErrCode),
    .earlyThresh(earlyThresh), .rdReq(rdReq), .discardReq(discardReq),
    .bytesUsed(bytesUsed), .descCount(descCount), .headDesc(headDesc),
    .stb(stb), .headStatus(headStatus), .wordValid(wordValid), .wordHasHi(wordHasHi),
    .receiving(receiving), .rxOverrun(rxOverrun), .statusOverrun(statusOverrun),
    .rxUnderrun(rxUnderrun), .rxComplete(rxComplete), .rxEarly(rxEarly)
  );

  rxbuf_datapath #(.DATA_DEPTH(DATA_DEPTH), .PKT_SLOTS(PKT_SLOTS)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrByte(wrByte),
    .bytesUsed(bytesUsed), .descCount(descCount), .headDesc(headDesc),
    .rdLo(rdLo), .rdHi(rdHi)
  );

  assign rdData      = wordValid ? {(wordHasHi ? rdHi : 8'h00), rdLo} : 16'h0000;
  assign adapterFail = rxUnderrun;

endmodule

// File: rtl/rx_pkt_buffer_chk.sv
module rx_pkt_buffer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rxReset,
  input logic        rdReq,
  input logic        discardReq,
  input logic [15:0] rdData,
  input logic [15:0] headStatus,
  input logic        receiving,
  input logic        statusOverrun,
  input logic        rxUnderrun,
  input logic        rxComplete,
  input logic        rxEarly
);

  p_read_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !discardReq && !rxReset && !headStatus[15] && headStatus[10:0] >= 11'd2)
    |=> (headStatus[10:0] == $past(headStatus[10:0]) - 11'd2));

  p_no_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!headStatus[15] && headStatus[10:0] == 11'd0) |-> (rdData == 16'h0000));

  p_full_has_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    statusOverrun |-> !headStatus[15]);

  p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !discardReq && !rxReset && !headStatus[15] && headStatus[10:0] == 11'd0)
    |=> rxUnderrun);

  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rxUnderrun && !rxReset) |=> rxUnderrun);

  p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rxReset |=> (headStatus == 16'h8000 && !rxUnderrun && !receiving && !rxComplete));

  p_complete_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rxComplete |-> !receiving);

  p_early_in_pkt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rxEarly |-> (receiving || rxComplete));

endmodule

bind rx_pkt_buffer rx_pkt_buffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rxReset(rxReset), .rdReq(rdReq), .discardReq(discardReq),
  .rdData(rdData), .headStatus(headStatus), .receiving(receiving),
  .statusOverrun(statusOverrun), .rxUnderrun(rxUnderrun),
  .rxComplete(rxComplete), .rxEarly(rxEarly)
);

// File: tb/rx_pkt_buffer_tb.sv
module rx_pkt_buffer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int SLOTS      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tRxReset = 0, tValid = 0, tStart = 0, tEnd = 0, tRd = 0, tDisc = 0;
  logic [3:0]  tCode = 0;
  logic [7:0]  tByte = 0;
  logic [10:0] tThresh = 0;
  logic [15:0] rdData, headStatus;
  logic receiving, rxOverrun, statusOverrun, rxUnderrun, adapterFail, rxComplete, rxEarly;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference model state
  byte unsigned mBytes[$];
  int mLen[$], mCode[$];
  int mCons = 0, mCur = 0;
  bit mIn = 0, mOvr = 0, mUnder = 0, mCompl = 0, mEarly = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_buffer #(.DATA_DEPTH(DEPTH), .PKT_SLOTS(SLOTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxReset(tRxReset), .wrValid(tValid), .wrStart(tStart),
    .wrEnd(tEnd), .wrErrCode(tCode), .wrByte(tByte), .earlyThresh(tThresh),
    .rdReq(tRd), .discardReq(tDisc), .rdData(rdData), .headStatus(headStatus),
    .receiving(receiving), .rxOverrun(rxOverrun), .statusOverrun(statusOverrun),
    .rxUnderrun(rxUnderrun), .adapterFail(adapterFail), .rxComplete(rxComplete),
    .rxEarly(rxEarly)
  );

  function automatic logic [3:0] classOf(int c);
    case (c)
      8, 9, 11, 12, 13, 2: return 4'(c);
      default:             return 4'd0;
    endcase
  endfunction

  function automatic int headRem();
    return (mLen.size() > 0) ? mLen[0] - mCons : 0;
  endfunction

  function automatic logic [15:0] expStatus();
    if (mLen.size() > 0) return {1'b0, classOf(mCode[0]), 11'(headRem())};
    return {1'b1, 4'b0000, (mIn ? 11'(mCur) : 11'd0)};
  endfunction

  function automatic logic [15:0] expData();
    int r = headRem();
    if (r >= 2) return {mBytes[1], mBytes[0]};
    if (r == 1) return {8'h00, mBytes[0]};
    return 16'h0000;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    int pktsPre = mLen.size();
    int usedPre = mBytes.size();
    int rem = headRem();
    bit startOk, active, take, hit, bOvr;
    int base, nc;
    mCompl = 0;
    mEarly = 0;
    if (tRxReset) begin
      mBytes.delete(); mLen.delete(); mCode.delete();
      mCons = 0; mIn = 0; mCur = 0; mOvr = 0; mUnder = 0;
      return;
    end
    startOk = tValid && tStart && !mIn && (pktsPre < SLOTS);
    active  = tValid && (mIn || startOk);
    base    = startOk ? 0 : mCur;
    bOvr    = startOk ? 1'b0 : mOvr;
    take    = active && (usedPre < DEPTH) && (base < 2047);
    hit     = active && (usedPre >= DEPTH);
    if (tDisc) begin
      if (pktsPre > 0) begin
        repeat (rem) void'(mBytes.pop_front());
        void'(mLen.pop_front());
        void'(mCode.pop_front());
        mCons = 0;
      end
    end else if (tRd) begin
      if (pktsPre > 0 && rem > 0) begin
        int a = (rem >= 2) ? 2 : 1;
        repeat (a) void'(mBytes.pop_front());
        mCons += a;
      end else mUnder = 1;
    end
    if (take) mBytes.push_back(tByte);
    nc = base + (take ? 1 : 0);
    if (active) begin
      mEarly = take && (tThresh != 0) && (nc == int'(tThresh));
      if (tEnd) begin
        mLen.push_back(nc);
        mCode.push_back((bOvr || hit) ? 8 : int'(tCode));
        mCompl = 1;
        mIn = 0;
      end else mIn = 1;
      mCur = nc;
      mOvr = bOvr || hit;
    end
  endtask

  task automatic compareAll();
    logic [15:0] es = expStatus();
    chk(es[15] ? "R3 head status" : "R2 head status", headStatus, es);
    chk("R4 read data", rdData, expData());
    chk("R10 receiving", 16'(receiving), 16'(mIn));
    chk("R11 complete pulse", 16'(rxComplete), 16'(mCompl));
    chk("R12 early pulse", 16'(rxEarly), 16'(mEarly));
    chk("R7 store full", 16'(rxOverrun), 16'(mBytes.size() == DEPTH));
    chk("R6 slots full", 16'(statusOverrun), 16'(mLen.size() == SLOTS));
    chk("R8 underrun", 16'(rxUnderrun), 16'(mUnder));
    chk("R8 adapter fail", 16'(adapterFail), 16'(mUnder));
  endtask

  task automatic beat(bit v, bit s, bit e, int code, int b, bit rd, bit disc, bit rr);
    tValid = v; tStart = s; tEnd = e; tCode = 4'(code); tByte = 8'(b);
    tRd = rd; tDisc = disc; tRxReset = rr;
    @(posedge clk);
    modelEdge();
    #(CLK_PERIOD/4);
    compareAll();
    tValid = 0; tStart = 0; tEnd = 0; tRd = 0; tDisc = 0; tRxReset = 0;
  endtask

  task automatic sendPkt(int n, int code, int firstByte);
    for (int i = 0; i < n; i++)
      beat(1, i == 0, i == n - 1, code, firstByte + i, 0, 0, 0);
  endtask

  task automatic idle();
    beat(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", headStatus, 16'h8000);
    chk("R1 data", rdData, 16'h0000);
    chk("R1 flags", 16'({receiving, rxOverrun, statusOverrun, rxUnderrun, adapterFail, rxComplete, rxEarly}), 16'h0000);

    // R2 / R4 / R12: five-byte CRC packet, threshold 3
    tThresh = 11'd3;
    sendPkt(5, 13, 8'h10);
    chk("R2 crc class", headStatus, 16'h6805);
    chk("R4 first word", rdData, 16'h1110);
    beat(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4 after read", headStatus, 16'h6803);
    beat(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4 odd tail", rdData, 16'h0014);
    beat(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4 drained", headStatus, 16'h6800);

    // R13 stray bytes
    for (int i = 0; i < 3; i++) beat(1, 0, 0, 0, 8'hEE, 0, 0, 0);
    chk("R13 stray ignored", headStatus, 16'h6800);
    chk("R13 not receiving", 16'(receiving), 16'h0);
    beat(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 discard to empty", headStatus, 16'h8000);

    // R2 unknown code, R5 priority and empty discard
    sendPkt(2, 7, 8'h40);
    chk("R2 unknown code shown as none", headStatus, 16'h0002);
    sendPkt(1, 2, 8'h50);
    beat(0, 0, 0, 0, 0, 1, 1, 0);
    chk("R5 discard wins", headStatus, 16'h1001);
    chk("R5 no underrun", 16'(rxUnderrun), 16'h0);
    beat(0, 0, 0, 0, 0, 0, 1, 0);
    beat(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 empty discard", headStatus, 16'h8000);

    // R6 descriptor queue full
    for (int i = 0; i < SLOTS; i++) sendPkt(1, 0, i);
    chk("R6 full flag", 16'(statusOverrun), 16'h1);
    sendPkt(3, 0, 8'h90);
    chk("R6 packet dropped", headStatus, 16'h0001);
    beat(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R6 clears on discard", 16'(statusOverrun), 16'h0);
    for (int i = 1; i < SLOTS; i++) beat(0, 0, 0, 0, 0, 0, 1, 0);

    // R7 byte store full
    tThresh = 11'd0;
    sendPkt(DEPTH + 6, 0, 0);
    chk("R7 full flag", 16'(rxOverrun), 16'h1);
    chk("R7 overrun class", headStatus, {1'b0, 4'b1000, 11'(DEPTH)});
    beat(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 clears on read", 16'(rxOverrun), 16'h0);
    beat(0, 0, 0, 0, 0, 0, 1, 0);

    // R8 underrun, R9 receive reset
    sendPkt(1, 0, 8'h77);
    beat(0, 0, 0, 0, 0, 1, 0, 0);
    beat(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 underrun set", 16'({rxUnderrun, adapterFail}), 16'h3);
    chk("R8 nothing consumed", headStatus, 16'h0000);
    idle();
    chk("R8 sticky", 16'(rxUnderrun), 16'h1);
    beat(1, 1, 0, 0, 1, 0, 0, 0);
    beat(1, 0, 0, 0, 2, 0, 0, 0);
    beat(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 status cleared", headStatus, 16'h8000);
    chk("R9 flags cleared", 16'({receiving, rxUnderrun, adapterFail}), 16'h0);

    // seeded random traffic
    for (int c = 0; c < 6000; c++) begin
      bit v = ($urandom_range(9) < 6);
      if (c % 500 == 0) tThresh = 11'($urandom_range(12));
      beat(v, v && !mIn && ($urandom_range(1) == 1), v && ($urandom_range(5) == 0),
           $urandom_range(15), $urandom_range(255),
           ($urandom_range(3) == 0), ($urandom_range(15) == 0), ($urandom_range(299) == 0));
    end

    done = 1;
    finishRun();
  end

endmodule